// File: doc/BRIEF.md
# Over-Current Pulse-Skip Sequencer

This block decides, for each channel of a multi-phase buck controller, what to do when the current-limit comparator trips. Each channel has a switching-cycle strobe, which marks the start of a cycle, and a digitised current-limit flag. The flag is looked at only on strobes. A trip seen while the channel is idle inhibits that channel's high-side drive. The inhibit covers the cycle in which the trip was seen and a fixed run of further cycles.

After the forced skip, the high-side drive is released. The channel then tests the flag on each strobe of an observation window.
- If the flag is seen again inside the window, a chip-wide over-current fault is latched. The latch inhibits every channel, and it also serves as the power-bad indication.
- If the window passes clean, the channel drops back to idle. A later trip then starts a fresh skip run.

The latched fault stays set until enable is dropped or reset is applied.

Top module: `oc_skip_seq`

## Requirements
- R1: After reset with enable high, every bit of `hs_inhibit` is 0 and `oc_fault` is 0.
- R2: A channel that is idle and sees a strobe with `ilim_det` high asserts its `hs_inhibit` bit from the next clock on.
- R3: That inhibit holds through the detecting cycle and the next SKIP_CYCLES strobes (default 8). Detects seen on those strobes have no effect.
- R4: On the strobe after the skip run (the 9th after the detect by default), the channel's `hs_inhibit` bit falls one clock later. This strobe opens the observation window.
- R5: A detect on any of the WATCH_CYCLES window strobes (default 8, the 9th through the 16th after the first detect) sets `oc_fault` one clock later. This includes the first and the last window strobe.
- R6: If no detect is seen on any window strobe, `oc_fault` stays 0 and the channel returns to idle. A detect on a later strobe then starts a new skip run.
- R7: While `oc_fault` is 1, every `hs_inhibit` bit is 1. `oc_fault` stays 1, whatever the strobes and detects do, until enable is low or reset is applied.
- R8: While `enable` is low, every `hs_inhibit` bit is 1 and `oc_fault` is cleared on the next clock. Strobes and detects are ignored. After enable returns, all channels are idle with their inhibits low.
- R9: Channels sequence independently: a strobe or detect on one channel does not change another channel's inhibit.
- R10: Clock cycles without a strobe on a channel neither advance its sequence nor sample its detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Regulator enable; low clears the fault and idles all channels |
| cyc_strobe | input | NUM_CH | One-clock pulse per channel marking the start of a switching cycle |
| ilim_det | input | NUM_CH | Per-channel current-limit detect, sampled only on that channel's strobe |
| hs_inhibit | output | NUM_CH | Per-channel high-side drive inhibit |
| oc_fault | output | 1 | Chip-wide latched over-current fault (also the power-bad indication) |

## Verification
The bench builds the block with two channels and the default windows: an 8-cycle skip run and an 8-cycle observation window. The strobe counts stay short enough to step each boundary by hand:
- the last skipped strobe and the first released one;
- the first and the last window strobe;
- the strobe just past a clean window.

With two channels, the bench can show one channel in its skip run while the other is strobed without effect. It also covers the chip-wide inhibit when either channel latches the fault.

// File: rtl/oc_seq_pkg.sv
package oc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SKIP  = 2'd1,
    SEQ_WATCH = 2'd2
  } seq_state_e;

  // Width of a counter able to hold the larger of the two phase lengths.
  function automatic int unsigned phase_cnt_bits(input int unsigned skip_len,
                                                 input int unsigned watch_len);
    int unsigned top;
    top = (skip_len > watch_len) ? skip_len : watch_len;
    return (top < 1) ? 1 : $clog2(top + 1);
  endfunction

  // True when 'checked' window strobes, counting the current one, fill the window.
  function automatic logic window_full(input int unsigned checked,
                                       input int unsigned watch_len);
    return (checked + 1) >= watch_len;
  endfunction

endpackage

// File: rtl/oc_channel_seq.sv
module oc_channel_seq
  import oc_seq_pkg::*;
#(
  parameter int unsigned SKIP_CYCLES  = 8,
  parameter int unsigned WATCH_CYCLES = 8,
  parameter int unsigned CNT_W        = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic strobe,
  input  logic det,
  output logic skip_o,
  output logic trip_o
);

  localparam logic [CNT_W-1:0] SKIP_LAST = CNT_W'(SKIP_CYCLES);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             skip_done;

  assign skip_done = (state_q == SEQ_SKIP) && (cnt_q == SKIP_LAST);

  // Detect on a window strobe (the strobe closing the skip run opens the window).
  assign trip_o = run && strobe && det &&
                  ((state_q == SEQ_WATCH) || skip_done);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!run) begin
      state_d = SEQ_IDLE;
      cnt_d   = '0;
    end else if (strobe) begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (det) begin
            state_d = SEQ_SKIP;
            cnt_d   = '0;
          end
        end
        SEQ_SKIP: begin
          if (!skip_done) begin
            cnt_d = cnt_q + 1'b1;
          end else if (det || window_full(0, WATCH_CYCLES)) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end else begin
            state_d = SEQ_WATCH;
            cnt_d   = CNT_W'(1);
          end
        end
        SEQ_WATCH: begin
          if (det || window_full(int'(cnt_q), WATCH_CYCLES)) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign skip_o = (state_q == SEQ_SKIP);

endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [NUM_CH-1:0] trip_vec,
  output logic              fault_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (!enable) begin
      fault_q <= 1'b0;
    end else if (|trip_vec) begin
      fault_q <= 1'b1;
    end
  end

endmodule

// File: rtl/oc_skip_seq.sv
module oc_skip_seq
  import oc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH       = 2,
  parameter int unsigned SKIP_CYCLES  = 8,
  parameter int unsigned WATCH_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [NUM_CH-1:0] cyc_strobe,
  input  logic [NUM_CH-1:0] ilim_det,
  output logic [NUM_CH-1:0] hs_inhibit,
  output logic              oc_fault
);

  localparam int unsigned CNT_W = phase_cnt_bits(SKIP_CYCLES, WATCH_CYCLES);

  logic              run;
  logic [NUM_CH-1:0] skip_vec;
  logic [NUM_CH-1:0] trip_vec;

  assign run = enable && !oc_fault;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    oc_channel_seq #(
      .SKIP_CYCLES (SKIP_CYCLES),
      .WATCH_CYCLES(WATCH_CYCLES),
      .CNT_W       (CNT_W)
    ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .strobe(cyc_strobe[ch]),
      .det   (ilim_det[ch]),
      .skip_o(skip_vec[ch]),
      .trip_o(trip_vec[ch])
    );

    assign hs_inhibit[ch] = !enable || oc_fault || skip_vec[ch];
  end

  oc_fault_latch #(
    .NUM_CH(NUM_CH)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .trip_vec(trip_vec),
    .fault_q (oc_fault)
  );

endmodule

// File: rtl/oc_skip_seq_chk.sv
module oc_skip_seq_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [NUM_CH-1:0] cyc_strobe,
  input logic [NUM_CH-1:0] ilim_det,
  input logic [NUM_CH-1:0] hs_inhibit,
  input logic              oc_fault,
  input logic [NUM_CH-1:0] trip_vec
);

  // R5
  trip_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && |trip_vec) |=> oc_fault);

  // R5
  fault_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oc_fault) |-> $past(|trip_vec));

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fault && enable) |=> oc_fault);

  // R7
  fault_inhibits_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |-> (&hs_inhibit));

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !oc_fault);

  // R8
  disable_inhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (&hs_inhibit));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R2
    start_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !hs_inhibit[ch] && cyc_strobe[ch] && ilim_det[ch]) |=> hs_inhibit[ch]);
  end

endmodule

bind oc_skip_seq oc_skip_seq_chk #(
  .NUM_CH(NUM_CH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cyc_strobe(cyc_strobe),
  .ilim_det  (ilim_det),
  .hs_inhibit(hs_inhibit),
  .oc_fault  (oc_fault),
  .trip_vec  (trip_vec)
);

// File: tb/oc_skip_seq_bench.sv
module oc_skip_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 2;
  localparam int SKIP_N     = 8;
  localparam int WATCH_N    = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           enable;
  logic [NCH-1:0] cyc_strobe;
  logic [NCH-1:0] ilim_det;
  logic [NCH-1:0] hs_inhibit;
  logic           oc_fault;

  int cyc    = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [NCH-1:0] inh;
    logic           flt;
    int             due;
    string          tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oc_skip_seq #(
    .NUM_CH      (NCH),
    .SKIP_CYCLES (SKIP_N),
    .WATCH_CYCLES(WATCH_N)
  ) u_oc_skip_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cyc_strobe(cyc_strobe),
    .ilim_det  (ilim_det),
    .hs_inhibit(hs_inhibit),
    .oc_fault  (oc_fault)
  );

  // Driver: apply one clock of stimulus and queue what must follow it.
  task automatic step(input logic [NCH-1:0] s, input logic [NCH-1:0] d,
                      input logic en_v, input logic [NCH-1:0] ei,
                      input logic ef, input string tag);
    exp_t e;
    @(negedge clk);
    cyc_strobe = s;
    ilim_det   = d;
    enable     = en_v;
    e.inh = ei;
    e.flt = ef;
    e.due = cyc + 1;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n      = 1'b0;
    cyc_strobe = '0;
    ilim_det   = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compare once the sampling edge has settled.
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (hs_inhibit !== e.inh || oc_fault !== e.flt) begin
        errors++;
        $display("FAIL %s: inhibit=%b fault=%b expected inhibit=%b fault=%b",
                 e.tag, hs_inhibit, oc_fault, e.inh, e.flt);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    enable     = 1'b1;
    cyc_strobe = '0;
    ilim_det   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step(2'b00, 2'b00, 1'b1, 2'b00, 1'b0, "R1 reset");

    // R2 channel 0 trips from idle
    step(2'b01, 2'b01, 1'b1, 2'b01, 1'b0, "R2 start");
    // R3 skip run; a detect in the middle is ignored; R10 gaps do not count
    for (int k = 1; k <= SKIP_N; k++) begin
      step(2'b01, (k == 4) ? 2'b01 : 2'b00, 1'b1, 2'b01, 1'b0, "R3 skip");
      if (k == 2) step(2'b00, 2'b01, 1'b1, 2'b01, 1'b0, "R10 no strobe");
      if (k == 5) step(2'b10, 2'b00, 1'b1, 2'b01, 1'b0, "R9 other channel");
    end
    // R4 strobe after the skip run releases the drive
    step(2'b01, 2'b00, 1'b1, 2'b00, 1'b0, "R4 release");
    // R6 clean window
    for (int k = 2; k <= WATCH_N; k++)
      step(2'b01, 2'b00, 1'b1, 2'b00, 1'b0, "R6 clean window");
    // R6 next detect restarts skipping, no fault
    step(2'b01, 2'b01, 1'b1, 2'b01, 1'b0, "R6 restart");
    // R9 channel 1 strobed with no detect while channel 0 skips
    step(2'b10, 2'b00, 1'b1, 2'b01, 1'b0, "R9 independent");
    for (int k = 1; k <= SKIP_N; k++)
      step(2'b01, 2'b00, 1'b1, 2'b01, 1'b0, "R3 skip again");
    step(2'b01, 2'b00, 1'b1, 2'b00, 1'b0, "R4 release again");
    for (int k = 2; k < WATCH_N; k++)
      step(2'b01, 2'b00, 1'b1, 2'b00, 1'b0, "R6 window");
    // R5 detect on the last window strobe
    step(2'b01, 2'b01, 1'b1, 2'b11, 1'b1, "R5 last window strobe");
    // R7 latch holds, all channels inhibited
    step(2'b00, 2'b00, 1'b1, 2'b11, 1'b1, "R7 hold");
    step(2'b11, 2'b00, 1'b1, 2'b11, 1'b1, "R7 hold strobes");
    step(2'b11, 2'b11, 1'b1, 2'b11, 1'b1, "R7 hold detects");
    // R8 enable low clears and ignores inputs
    step(2'b00, 2'b00, 1'b0, 2'b11, 1'b0, "R8 disable clears");
    step(2'b11, 2'b11, 1'b0, 2'b11, 1'b0, "R8 disabled ignores");
    step(2'b00, 2'b00, 1'b1, 2'b00, 1'b0, "R8 re-enable idle");

    // Channel 1: detect on the first window strobe
    step(2'b10, 2'b10, 1'b1, 2'b10, 1'b0, "R2 start ch1");
    for (int k = 1; k <= SKIP_N; k++)
      step(2'b10, 2'b00, 1'b1, 2'b10, 1'b0, "R3 skip ch1");
    step(2'b10, 2'b10, 1'b1, 2'b11, 1'b1, "R5 first window strobe");
    step(2'b00, 2'b00, 1'b1, 2'b11, 1'b1, "R7 latched ch1");

    // R7 reset clears the latch
    do_reset();
    step(2'b00, 2'b00, 1'b1, 2'b00, 1'b0, "R7 reset clears");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule